// File: doc/BRIEF.md
# Target Command Sequencer

This block runs the target side of a SCSI-style controller. It takes one command at a time from a strobe and an 8-bit opcode. It then drives the 3-bit bus phase code and a connected flag, and it records the outcome in five sticky status bits. A separate transfer path moves the bytes. It reports each byte through a done pulse, with a flag that marks the final byte of the transfer.

Three opcodes each start a transfer in one phase. The first is a message-in transfer, the second a status transfer and the third a data-in transfer. A fourth opcode runs a two-step exit. The target first sends two save-data-pointer message bytes and then drops off the bus. If the initiator raises ATN during this exit, it is cut short and the target stays connected. A bus reset overrides everything, and the host clears the status bits with a strobe.

Top module: `tgt_cmd_seq`

## Requirements
- R1: After reset, phase is 000, connected is 0, cmd_clr is 0 and all five status bits are 0.
- R2: A target opcode received while tgt_mode is 0 sets st_ill and pulses cmd_clr for one cycle. Phase and connected do not change.
- R3: In target mode, the cycle after the strobe, connected is 1 and phase shows the command's phase. Opcode 20h selects message-in (111), 21h selects status (011), 22h selects data-in (001) and 23h selects message-in (111).
- R4: Opcode bit 7 is a DMA-mode flag and does not change decoding or sequencing. For example, A2h behaves exactly like 22h.
- R5: A transfer command completes on a byte_done that has byte_last set. st_so rises the next cycle. Phase and connected hold until then and after it, and byte_done without byte_last does not complete the transfer.
- R6: ATN high while a command runs sets st_sr, and the transfer continues in its phase.
- R7: A rising ATN while idle sets st_sr, clears st_so and pulses cmd_clr for one cycle.
- R8: The disconnect opcode counts two byte_done pulses in message-in and ignores byte_last. One cycle after the second pulse, connected falls, phase returns to 000, and st_so and st_disc are set.
- R9: ATN during either step of the disconnect sequence sets st_so and st_sr and pulses cmd_clr. The sequence ends with connected still 1 and st_disc still 0.
- R10: bus_rst returns the block to idle the next cycle, with connected at 0 and phase at 000. It sets st_brst only when rst_int_en is 1.
- R11: stat_clr clears all status bits the next cycle. A set event in the same cycle wins.
- R12: Opcodes other than the four target commands, and any strobe while a command runs, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Opcode; bit 7 is the DMA flag |
| tgt_mode | input | 1 | Device is in target mode |
| atn_in | input | 1 | ATN from the initiator |
| bus_rst | input | 1 | Bus reset seen |
| rst_int_en | input | 1 | Enables the bus-reset status bit |
| byte_done | input | 1 | Transfer path finished one byte |
| byte_last | input | 1 | That byte was the final one of the transfer |
| stat_clr | input | 1 | Host read-clear of the status bits |
| phase | output | 3 | Bus phase code (MSG, C/D, I/O) |
| connected | output | 1 | Target holds the bus |
| cmd_clr | output | 1 | One-cycle command register clear |
| st_so | output | 1 | Successful operation |
| st_sr | output | 1 | Service request |
| st_disc | output | 1 | Disconnected |
| st_ill | output | 1 | Illegal command |
| st_brst | output | 1 | Bus reset |

## Verification
The hardest case to reach is ATN arriving in the one-cycle gap after the second save-data-pointer byte, just before the target leaves the bus. There the abort must win over the disconnect. The bench runs the disconnect sequence three times, raising ATN after zero, one and two counted bytes, so the last run lands on exactly that cycle. It also sweeps every opcode in both modes to cover decoding and the ignored opcodes.

// File: rtl/tgt_seq_pkg.sv
package tgt_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_XFER  = 2'd1,
    S_DMSG  = 2'd2,
    S_DSTEP = 2'd3
  } seq_st_t;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_MSG  = 3'd1,
    OP_STAT = 3'd2,
    OP_DATA = 3'd3,
    OP_DISC = 3'd4
  } op_kind_t;

  localparam logic [2:0] PH_NONE  = 3'b000;
  localparam logic [2:0] PH_DIN   = 3'b001;
  localparam logic [2:0] PH_STAT  = 3'b011;
  localparam logic [2:0] PH_MSGIN = 3'b111;

  localparam int unsigned NSTAT = 5;
  localparam int unsigned B_SO   = 0;
  localparam int unsigned B_SR   = 1;
  localparam int unsigned B_DISC = 2;
  localparam int unsigned B_ILL  = 3;
  localparam int unsigned B_BRST = 4;

endpackage

// File: rtl/tgt_op_decode.sv
module tgt_op_decode
  import tgt_seq_pkg::*;
#(
  parameter int unsigned OPW = 8
) (
  input  logic [OPW-1:0] op,
  output op_kind_t       kind,
  output logic [2:0]     op_ph
);
  localparam int unsigned BW = OPW - 1;

  logic [BW-1:0] base;

  // top bit is the DMA flag and takes no part in decoding
  assign base = op[BW-1:0];

  always_comb begin
    kind  = OP_NONE;
    op_ph = PH_NONE;
    if (base == BW'('h20)) begin
      kind  = OP_MSG;
      op_ph = PH_MSGIN;
    end else if (base == BW'('h21)) begin
      kind  = OP_STAT;
      op_ph = PH_STAT;
    end else if (base == BW'('h22)) begin
      kind  = OP_DATA;
      op_ph = PH_DIN;
    end else if (base == BW'('h23)) begin
      kind  = OP_DISC;
      op_ph = PH_MSGIN;
    end
  end
endmodule

// File: rtl/tgt_seq_fsm.sv
module tgt_seq_fsm
  import tgt_seq_pkg::*;
#(
  parameter int unsigned SDP_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  op_kind_t         kind,
  input  logic [2:0]       op_ph,
  input  logic             tgt_mode,
  input  logic             atn,
  input  logic             atn_rise,
  input  logic             bus_rst,
  input  logic             rst_int_en,
  input  logic             byte_done,
  input  logic             byte_last,
  output seq_st_t          st,
  output logic [2:0]       phase,
  output logic             connected,
  output logic             cmd_clr,
  output logic [NSTAT-1:0] set_v,
  output logic             so_kill
);
  localparam int unsigned CW = (SDP_N < 2) ? 1 : $clog2(SDP_N + 1);

  seq_st_t    st_q, st_d;
  logic [2:0] ph_q, ph_d;
  logic       conn_q, conn_d;
  logic       cc_q, cc_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    conn_d  = conn_q;
    cc_d    = 1'b0;
    cnt_d   = cnt_q;
    set_v   = '0;
    so_kill = 1'b0;
    if (bus_rst) begin
      st_d   = S_IDLE;
      ph_d   = PH_NONE;
      conn_d = 1'b0;
      cnt_d  = '0;
      set_v[B_BRST] = rst_int_en;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (cmd_valid && kind != OP_NONE) begin
            if (!tgt_mode) begin
              set_v[B_ILL] = 1'b1;
              cc_d         = 1'b1;
            end else begin
              conn_d = 1'b1;
              ph_d   = op_ph;
              cnt_d  = '0;
              st_d   = (kind == OP_DISC) ? S_DMSG : S_XFER;
            end
          end else if (atn_rise) begin
            set_v[B_SR] = 1'b1;
            so_kill     = 1'b1;
            cc_d        = 1'b1;
          end
        end
        S_XFER: begin
          if (atn) set_v[B_SR] = 1'b1;
          if (byte_done && byte_last) begin
            set_v[B_SO] = 1'b1;
            st_d        = S_IDLE;
          end
        end
        S_DMSG: begin
          if (atn) begin
            set_v[B_SO] = 1'b1;
            set_v[B_SR] = 1'b1;
            cc_d        = 1'b1;
            st_d        = S_IDLE;
          end else if (byte_done) begin
            if (cnt_q == CW'(SDP_N - 1)) begin
              cnt_d = '0;
              st_d  = S_DSTEP;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        S_DSTEP: begin
          set_v[B_SO] = 1'b1;
          st_d        = S_IDLE;
          if (atn) begin
            set_v[B_SR] = 1'b1;
            cc_d        = 1'b1;
          end else begin
            set_v[B_DISC] = 1'b1;
            conn_d        = 1'b0;
            ph_d          = PH_NONE;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ph_q   <= PH_NONE;
      conn_q <= 1'b0;
      cc_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      conn_q <= conn_d;
      cc_q   <= cc_d;
      cnt_q  <= cnt_d;
    end
  end

  assign st        = st_q;
  assign phase     = ph_q;
  assign connected = conn_q;
  assign cmd_clr   = cc_q;
endmodule

// File: rtl/tgt_status_bits.sv
module tgt_status_bits
  import tgt_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] set_v,
  input  logic             so_kill,
  input  logic             stat_clr,
  output logic [NSTAT-1:0] stat
);
  logic [NSTAT-1:0] clr_v;

  always_comb begin
    clr_v = {NSTAT{stat_clr}};
    clr_v[B_SO] = stat_clr | so_kill;
  end

  for (genvar gi = 0; gi < NSTAT; gi++) begin : g_bit
    logic en;
    assign en = set_v[gi] | clr_v[gi];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stat[gi] <= 1'b0;
      else if (en) stat[gi] <= set_v[gi];
    end
  end
endmodule

// File: rtl/tgt_cmd_seq.sv
module tgt_cmd_seq
  import tgt_seq_pkg::*;
#(
  parameter int unsigned OPW    = 8,
  parameter int unsigned SDP_N  = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [OPW-1:0] cmd_op,
  input  logic           tgt_mode,
  input  logic           atn_in,
  input  logic           bus_rst,
  input  logic           rst_int_en,
  input  logic           byte_done,
  input  logic           byte_last,
  input  logic           stat_clr,
  output logic [2:0]     phase,
  output logic           connected,
  output logic           cmd_clr,
  output logic           st_so,
  output logic           st_sr,
  output logic           st_disc,
  output logic           st_ill,
  output logic           st_brst
);
  logic [SYNC_N-1:0] rs_q;
  logic              rst_sn;
  logic              atn_q;
  logic              atn_rise;
  op_kind_t          kind;
  logic [2:0]        op_ph;
  seq_st_t           seq_st;
  logic              seq_busy;
  logic [NSTAT-1:0]  set_v;
  logic              so_kill;
  logic [NSTAT-1:0]  stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_sn = rs_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) atn_q <= 1'b0;
    else         atn_q <= atn_in;
  end
  assign atn_rise = atn_in & ~atn_q;

  tgt_op_decode #(.OPW(OPW)) u_dec (
    .op    (cmd_op),
    .kind  (kind),
    .op_ph (op_ph)
  );

  tgt_seq_fsm #(.SDP_N(SDP_N)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sn),
    .cmd_valid  (cmd_valid),
    .kind       (kind),
    .op_ph      (op_ph),
    .tgt_mode   (tgt_mode),
    .atn        (atn_in),
    .atn_rise   (atn_rise),
    .bus_rst    (bus_rst),
    .rst_int_en (rst_int_en),
    .byte_done  (byte_done),
    .byte_last  (byte_last),
    .st         (seq_st),
    .phase      (phase),
    .connected  (connected),
    .cmd_clr    (cmd_clr),
    .set_v      (set_v),
    .so_kill    (so_kill)
  );

  tgt_status_bits u_stat (
    .clk      (clk),
    .rst_n    (rst_sn),
    .set_v    (set_v),
    .so_kill  (so_kill),
    .stat_clr (stat_clr),
    .stat     (stat)
  );

  assign seq_busy = (seq_st != S_IDLE);
  assign st_so   = stat[B_SO];
  assign st_sr   = stat[B_SR];
  assign st_disc = stat[B_DISC];
  assign st_ill  = stat[B_ILL];
  assign st_brst = stat[B_BRST];
endmodule

// File: rtl/tgt_cmd_seq_chk.sv
module tgt_cmd_seq_chk #(
  parameter int unsigned OPW = 8
) (
  input logic           clk,
  input logic           rst_sn,
  input logic           cmd_valid,
  input logic [OPW-1:0] cmd_op,
  input logic           tgt_mode,
  input logic           atn_in,
  input logic           bus_rst,
  input logic           rst_int_en,
  input logic           byte_done,
  input logic           stat_clr,
  input logic           busy,
  input logic [2:0]     phase,
  input logic           connected,
  input logic           cmd_clr,
  input logic           st_so,
  input logic           st_sr,
  input logic           st_disc,
  input logic           st_ill,
  input logic           st_brst
);
  logic tgt_op;
  logic atn_d;

  assign tgt_op = (cmd_op[OPW-2:0] >= (OPW-1)'('h20)) &&
                  (cmd_op[OPW-2:0] <= (OPW-1)'('h23));

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) atn_d <= 1'b0;
    else         atn_d <= atn_in;
  end

  p_ill_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy && cmd_valid && tgt_op && !tgt_mode && !bus_rst) |=> (st_ill && cmd_clr));

  p_conn_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy && cmd_valid && tgt_op && tgt_mode && !bus_rst) |=> connected);

  p_ph_hold_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && !bus_rst) |=> ($stable(phase) || !connected));

  p_sr_busy_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && atn_in && !bus_rst) |=> st_sr);

  p_idle_atn_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (!busy && !cmd_valid && !bus_rst && atn_in && !atn_d) |=> (st_sr && !st_so && cmd_clr));

  p_disc_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(st_disc) |-> (!connected && phase == 3'b000));

  p_brst_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    bus_rst |=> (!connected && phase == 3'b000 && !busy));

  p_brst_flag_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rst && rst_int_en) |=> st_brst);

  p_clr_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    (stat_clr && !busy && !bus_rst && !cmd_valid && !atn_in && !byte_done)
      |=> !(st_so || st_sr || st_disc || st_ill || st_brst));
endmodule

bind tgt_cmd_seq tgt_cmd_seq_chk #(.OPW(OPW)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .tgt_mode   (tgt_mode),
  .atn_in     (atn_in),
  .bus_rst    (bus_rst),
  .rst_int_en (rst_int_en),
  .byte_done  (byte_done),
  .stat_clr   (stat_clr),
  .busy       (seq_busy),
  .phase      (phase),
  .connected  (connected),
  .cmd_clr    (cmd_clr),
  .st_so      (st_so),
  .st_sr      (st_sr),
  .st_disc    (st_disc),
  .st_ill     (st_ill),
  .st_brst    (st_brst)
);

// File: tb/sim_tgt_cmd_seq.sv
`timescale 1ns/1ps
module sim_tgt_cmd_seq;
  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_op;
  logic       tgt_mode, atn_in, bus_rst, rst_int_en;
  logic       byte_done, byte_last, stat_clr;
  logic [2:0] phase;
  logic       connected, cmd_clr;
  logic       st_so, st_sr, st_disc, st_ill, st_brst;

  int n_chk;
  int n_err;
  bit done;

  tgt_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .tgt_mode(tgt_mode), .atn_in(atn_in), .bus_rst(bus_rst),
    .rst_int_en(rst_int_en), .byte_done(byte_done), .byte_last(byte_last),
    .stat_clr(stat_clr), .phase(phase), .connected(connected),
    .cmd_clr(cmd_clr), .st_so(st_so), .st_sr(st_sr), .st_disc(st_disc),
    .st_ill(st_ill), .st_brst(st_brst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // status vector order: {brst, ill, disc, sr, so}
  function automatic logic [4:0] stv();
    return {st_brst, st_ill, st_disc, st_sr, st_so};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; tgt_mode = 0; atn_in = 0;
    bus_rst = 0; rst_int_en = 0; byte_done = 0; byte_last = 0; stat_clr = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic send(input logic [7:0] op, input logic mode);
    cmd_valid = 1'b1; cmd_op = op; tgt_mode = mode;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic xbyte(input logic last);
    byte_done = 1'b1; byte_last = last;
    tick();
    byte_done = 1'b0; byte_last = 1'b0;
  endtask

  function automatic logic [2:0] exp_ph(input logic [6:0] b);
    case (b)
      7'h20: return 3'b111;
      7'h21: return 3'b011;
      7'h22: return 3'b001;
      7'h23: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    do_reset();
    // R1 reset state
    chk("R1 phase", 32'(phase), 0);
    chk("R1 conn/cmd_clr", 32'({connected, cmd_clr}), 0);
    chk("R1 status", 32'(stv()), 0);

    // sweep every opcode in both modes: R2 R3 R4 R12
    for (int op = 0; op < 256; op++) begin
      for (int m = 0; m < 2; m++) begin
        logic is_t;
        logic [8:0] exp;
        string tag;
        do_reset();
        send(8'(op), m[0]);
        is_t = (op[6:0] >= 7'h20) && (op[6:0] <= 7'h23);
        if (!is_t)        begin exp = 9'd0; tag = "R12 other opcode"; end
        else if (m == 0)  begin exp = {1'b0, 3'b000, 5'b01000}; tag = "R2 not target mode"; end
        else begin
          exp = {1'b1, exp_ph(op[6:0]), 5'b00000};
          tag = op[7] ? "R4 dma flag variant" : "R3 phase select";
        end
        chk(tag, 32'({connected, phase, stv()}), 32'(exp));
        chk(tag, 32'(cmd_clr), 32'(is_t && m == 0));
      end
    end

    // R5 completion after n bytes, also bit7 set (R4)
    for (int k = 0; k < 6; k++) begin
      for (int n = 1; n <= 4; n++) begin
        logic [7:0] op;
        op = 8'(8'h20 + (k % 3)) | (k >= 3 ? 8'h80 : 8'h00);
        do_reset();
        send(op, 1'b1);
        for (int b = 0; b < n - 1; b++) xbyte(1'b0);
        chk("R5 no early finish", 32'({connected, phase, st_so}), 32'({1'b1, exp_ph(op[6:0]), 1'b0}));
        xbyte(1'b1);
        chk("R5 finish sets so", 32'({connected, phase, st_so}), 32'({1'b1, exp_ph(op[6:0]), 1'b1}));
        xbyte(1'b1);
        chk("R5 idle after finish", 32'(stv()), 32'd1);
      end
    end

    // R6 ATN during transfer; R12 strobe while busy
    do_reset();
    send(8'h22, 1'b1);
    send(8'h20, 1'b1);
    chk("R12 busy strobe ignored", 32'({phase, cmd_clr, st_ill}), 32'({3'b001, 2'b00}));
    atn_in = 1'b1; tick(); atn_in = 1'b0;
    chk("R6 sr during transfer", 32'({connected, phase, st_sr, st_so}), 32'({1'b1, 3'b001, 2'b10}));
    xbyte(1'b1);
    chk("R6 transfer still completes", 32'(stv()), 32'b00011);

    // R7 idle ATN rise
    do_reset();
    send(8'h21, 1'b1);
    xbyte(1'b1);
    chk("R7 setup so", 32'(st_so), 1);
    atn_in = 1'b1; tick();
    chk("R7 idle atn", 32'({st_sr, st_so, cmd_clr}), 32'b101);
    tick();
    chk("R7 single pulse", 32'(cmd_clr), 0);
    atn_in = 1'b0; tick();

    // R8 disconnect sequence
    for (int v = 0; v < 2; v++) begin
      do_reset();
      send(v ? 8'hA3 : 8'h23, 1'b1);
      chk("R8 msg-in", 32'({connected, phase}), 32'({1'b1, 3'b111}));
      xbyte(1'b1);
      chk("R8 last flag ignored", 32'({connected, st_so}), 32'b10);
      xbyte(1'b0);
      chk("R8 step two pending", 32'({connected, st_so, st_disc}), 32'b100);
      tick();
      chk("R8 disconnected", 32'({connected, phase, stv()}), 32'({1'b0, 3'b000, 5'b00101}));
    end

    // R9 ATN after 0, 1 or 2 counted bytes
    for (int k = 0; k < 3; k++) begin
      do_reset();
      send(8'h23, 1'b1);
      for (int b = 0; b < k; b++) xbyte(1'b0);
      atn_in = 1'b1; tick(); atn_in = 1'b0;
      chk("R9 abort keeps bus", 32'({connected, cmd_clr, stv()}), 32'({2'b11, 5'b00011}));
      tick();
      chk("R9 no late disconnect", 32'({connected, st_disc}), 32'b10);
    end

    // R10 bus reset in several states, both enables; R11 clear
    for (int en = 0; en < 2; en++) begin
      for (int s = 0; s < 3; s++) begin
        do_reset();
        send(s == 2 ? 8'h23 : 8'h22, 1'b1);
        if (s == 0) xbyte(1'b1);
        bus_rst = 1'b1; rst_int_en = en[0]; tick(); bus_rst = 1'b0;
        chk("R10 bus reset drops bus", 32'({connected, phase}), 0);
        chk("R10 brst flag", 32'(st_brst), 32'(en));
        xbyte(1'b1); xbyte(1'b0); tick();
        chk("R10 back to idle", 32'({connected, st_disc, st_so}), 32'({2'b00, s == 0}));
        stat_clr = 1'b1; tick(); stat_clr = 1'b0;
        chk("R11 status cleared", 32'(stv()), 0);
      end
    end

    // R11 set wins over clear
    do_reset();
    send(8'h20, 1'b0);
    stat_clr = 1'b1; send(8'h20, 1'b0); stat_clr = 1'b0;
    chk("R11 set wins", 32'(st_ill), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule